// File: doc/BRIEF.md
# Frequency-Tracking Supply and Body-Bias Controller

This controller sits beside an SRAM macro and picks the macro's supply and body-bias settings from the rate of the clock that drives it. It counts edges of the monitored clock over a fixed window of a slower reference clock. The count is turned into one of eleven supply-voltage codes through a monotonic set of band limits. The bias code follows from the chosen supply code. The analog regulator and the bias generator are outside the block: they see only the two code outputs and return a single acknowledge pulse once the new levels have settled.

Changes are sequenced so that the memory is never clocked faster than its supply allows. A move to a higher supply code drops the ready flag until the regulator acknowledges, and ready then tells the clock source that the faster clock is safe. A move to a lower code happens only after the slower clock has been measured, so ready stays high throughout. A standby request parks the macro at the lowest supply and strongest reverse bias. Release of the request restores the last active point before ready returns. Lowering the code needs a margin of a few counts past the band edge, so a clock sitting on a boundary does not make the codes toggle.

Top module: `dvfb_ctrl`

## Requirements
- R1: After reset the supply code is 10, the bias code is 0, ready is 1 and in_standby is 0.
- R2: Supply code k stands for 500 + 50*k mV, k from 0 to 10. The active target is the number of limits LO_CNT + j*STEP_CNT (j = 0..9) that the edge count over one window of WIN reference cycles exceeds; the defaults are WIN = 16, LO_CNT = 32 and STEP_CNT = 29.
- R3: Bias code b stands for a threshold shift of -100 + 50*b mV, b from 0 to 4. In active operation the bias code is 3 for supply codes 0 to 2, 2 for codes 3 to 5, 1 for codes 6 to 8 and 0 for codes 9 and 10.
- R4: When the supply code rises, ready falls in the same cycle and rises only on the clock edge that samples reg_ack high.
- R5: When the supply code falls because a slower clock was measured, ready stays high.
- R6: A higher target is applied at once. A lower target is applied only when the count is at most LO_CNT + (c-1)*STEP_CNT - HYST, with c the current code and HYST = 4 by default; otherwise the code holds.
- R7: With sleep_req high while running, the codes become supply 0 and bias 4, ready falls, and in_standby rises once reg_ack arrives. The codes then hold whatever the monitored clock does.
- R8: When sleep_req falls in standby, the last active supply and bias codes are restored first. in_standby falls at once, and ready rises on the edge that samples reg_ack.
- R9: While a change waits for reg_ack, neither code moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the measurement window and the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored clock whose rate selects the operating point |
| sleep_req | input | 1 | High requests the standby point, low requests active operation |
| reg_ack | input | 1 | One-cycle pulse: the commanded levels have settled |
| vdd_code | output | 4 | Supply-voltage code, 50 mV per step from 500 mV |
| bias_code | output | 3 | Threshold-shift code, 50 mV per step from -100 mV |
| ready | output | 1 | The current monitored clock rate is safe for the applied supply |
| in_standby | output | 1 | The standby point is applied and acknowledged |

## Verification
The monitored clock runs at periods of 12, 2.0, 2.2, 2.4, 1.0 and 3.0 ns, each chosen to put the window count well inside one band. This tells the band lookup apart from an off-by-one at the limits. A fall from the top code to the bottom code shows whether ready stays high on the way down. A rise with the acknowledge held back shows whether ready and the codes wait for the regulator. The 2.2 ns period sits just under the band edge and must leave the code alone, while 2.4 ns must lower it. That pair separates the hysteresis from a plain lookup. The standby pass changes the clock rate while parked, to show that the standby codes hold and that wake-up restores the old point before moving to the new one.

// File: rtl/dvfb_ctrl.sv
module dvfb_ctrl #(
  parameter int WIN      = 16,
  parameter int CNT_W    = 10,
  parameter int LO_CNT   = 32,
  parameter int STEP_CNT = 29,
  parameter int HYST     = 4,
  parameter int VTOP     = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mon_clk,
  input  logic       sleep_req,
  input  logic       reg_ack,
  output logic [3:0] vdd_code,
  output logic [2:0] bias_code,
  output logic       ready,
  output logic       in_standby
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [2:0] BIAS_PARK = 3'd4;

  typedef enum logic [2:0] {S_RUN, S_SETTLE, S_ENTER, S_SLEEP, S_WAKE} st_t;
  st_t st;

  logic [CNT_W-1:0] mon_bin, mon_nxt, mon_gray;
  assign mon_nxt = mon_bin + 1'b1;

  always_ff @(posedge mon_clk or negedge rst_n)
    if (!rst_n) begin
      mon_bin  <= '0;
      mon_gray <= '0;
    end else begin
      mon_bin  <= mon_nxt;
      mon_gray <= mon_nxt ^ (mon_nxt >> 1);
    end

  logic [CNT_W-1:0] g_s1, g_s2, g_bin, snap, delta;
  logic [WIN_W-1:0] win_cnt;
  logic             primed, meas_vld;
  wire              tick = (win_cnt == WIN_W'(WIN - 1));

  for (genvar i = 0; i < CNT_W; i++) begin : g_ungray
    assign g_bin[i] = ^(g_s2 >> i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      g_s1 <= '0; g_s2 <= '0; snap <= '0; delta <= '0;
      win_cnt <= '0; primed <= 1'b0; meas_vld <= 1'b0;
    end else begin
      g_s1     <= mon_gray;
      g_s2     <= g_s1;
      win_cnt  <= tick ? '0 : win_cnt + 1'b1;
      meas_vld <= 1'b0;
      if (tick) begin
        snap     <= g_bin;
        delta    <= g_bin - snap;
        meas_vld <= primed;
        primed   <= 1'b1;
      end
    end

  logic [3:0] vdd_act, tgt;
  logic       move;

  always_comb begin
    int raw, d, cur;
    d   = int'(delta);
    cur = int'(vdd_act);
    raw = 0;
    for (int j = 0; j < VTOP; j++)
      if (d > LO_CNT + j * STEP_CNT) raw++;
    tgt  = 4'(raw);
    move = (raw > cur) ||
           ((raw < cur) && (d + HYST <= LO_CNT + (cur - 1) * STEP_CNT));
  end

  function automatic logic [2:0] bias_for(input logic [3:0] v);
    if (v <= 4'd2)      return 3'd3;
    else if (v <= 4'd5) return 3'd2;
    else if (v <= 4'd8) return 3'd1;
    else                return 3'd0;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_RUN;
      vdd_act   <= 4'(VTOP);
      vdd_code  <= 4'(VTOP);
      bias_code <= bias_for(4'(VTOP));
      ready     <= 1'b1;
    end else begin
      case (st)
        S_RUN:
          if (sleep_req) begin
            vdd_code  <= '0;
            bias_code <= BIAS_PARK;
            ready     <= 1'b0;
            st        <= S_ENTER;
          end else if (meas_vld && move) begin
            vdd_act   <= tgt;
            vdd_code  <= tgt;
            bias_code <= bias_for(tgt);
            if (tgt > vdd_act) ready <= 1'b0;
            st        <= S_SETTLE;
          end
        S_SETTLE:
          if (reg_ack) begin
            ready <= 1'b1;
            st    <= S_RUN;
          end
        S_ENTER:
          if (reg_ack) st <= S_SLEEP;
        S_SLEEP:
          if (!sleep_req) begin
            vdd_code  <= vdd_act;
            bias_code <= bias_for(vdd_act);
            st        <= S_WAKE;
          end
        S_WAKE:
          if (reg_ack) begin
            ready <= 1'b1;
            st    <= S_RUN;
          end
        default: st <= S_RUN;
      endcase
    end

  assign in_standby = (st == S_SLEEP);

  AST_VDD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vdd_code <= 4'(VTOP)); // R2
  AST_BIAS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bias_code <= BIAS_PARK); // R3
  AST_UP_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (vdd_code > $past(vdd_code)) |-> !ready); // R4
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(reg_ack)); // R4
  AST_PARK_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ENTER || st == S_SLEEP) |-> (vdd_code == 4'd0 && bias_code == BIAS_PARK)); // R7
  AST_HOLD_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && !reg_ack) |=> ($stable(vdd_code) && $stable(bias_code))); // R9
endmodule

// File: tb/test_dvfb_ctrl.sv
`timescale 1ns/1ps
module test_dvfb_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, mon_clk = 1'b0, sleep_req = 1'b0, reg_ack = 1'b0;
  logic [3:0] vdd_code;
  logic [2:0] bias_code;
  logic ready, in_standby;
  int total = 0, bad = 0;
  bit done = 0, ack_hold = 0, reg_live = 0;
  realtime mon_half = 6.0;

  dvfb_ctrl i_dvfb_ctrl (.clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .sleep_req(sleep_req),
    .reg_ack(reg_ack), .vdd_code(vdd_code), .bias_code(bias_code), .ready(ready),
    .in_standby(in_standby));

  always #10 clk = ~clk;
  initial forever #(mon_half) mon_clk = ~mon_clk;

  initial begin : regulator
    logic [6:0] last;
    int pend, dly;
    pend = 0; dly = 0; last = {4'd10, 3'd0};
    forever begin
      @(negedge clk);
      reg_ack = 1'b0;
      if (reg_live) begin
        if ({vdd_code, bias_code} != last) begin
          last = {vdd_code, bias_code}; pend = 1; dly = 5;
        end else if (pend == 1) begin
          if (dly > 0) dly--;
          else if (!ack_hold) begin reg_ack = 1'b1; pend = 0; end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_change(input logic [3:0] old, output bit seen);
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (vdd_code != old) seen = 1;
    end
  endtask

  task automatic t_reset;
    chk(vdd_code == 4'd10, "R1 vdd", vdd_code, 10);
    chk(bias_code == 3'd0, "R1 bias", bias_code, 0);
    chk(ready && !in_standby, "R1 ready/standby", {ready, in_standby}, 2);
  endtask

  task automatic t_down_to_min;
    bit dropped = 0;
    mon_half = 6.0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!ready) dropped = 1; end
    chk(!dropped, "R5 ready held while lowering", dropped, 0);
    chk(vdd_code == 4'd0, "R2 vdd at 83MHz", vdd_code, 0);
    chk(bias_code == 3'd3, "R3 bias for code 0", bias_code, 3);
  endtask

  task automatic t_up_held_ack;
    bit seen, steady;
    logic [3:0] v0;
    ack_hold = 1;
    mon_half = 1.0;
    wait_change(4'd0, seen);
    chk(seen, "R4 rise seen", seen, 1);
    chk(!ready, "R4 ready low on rise", ready, 0);
    v0 = vdd_code; steady = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (vdd_code != v0 || ready) steady = 0;
    end
    chk(steady, "R9 codes and ready held without ack", steady, 1);
    ack_hold = 0;
    cycles(200);
    chk(vdd_code == 4'd5, "R2 vdd at 500MHz", vdd_code, 5);
    chk(bias_code == 3'd2, "R3 bias for code 5", bias_code, 2);
    chk(ready, "R4 ready after ack", ready, 1);
  endtask

  task automatic t_hysteresis;
    mon_half = 1.1;
    cycles(200);
    chk(vdd_code == 4'd5, "R6 near edge holds", vdd_code, 5);
    mon_half = 1.2;
    cycles(200);
    chk(vdd_code == 4'd4, "R6 clearly below lowers", vdd_code, 4);
    chk(bias_code == 3'd2 && ready, "R3 bias for code 4", bias_code, 2);
  endtask

  task automatic t_top;
    mon_half = 0.5;
    cycles(200);
    chk(vdd_code == 4'd10, "R2 vdd at 1GHz", vdd_code, 10);
    chk(bias_code == 3'd0 && ready, "R3 bias for code 10", bias_code, 0);
  endtask

  task automatic t_standby;
    bit steady = 1;
    sleep_req = 1'b1;
    @(negedge clk);
    chk(vdd_code == 4'd0 && bias_code == 3'd4, "R7 park codes", {vdd_code, bias_code}, 4);
    chk(!ready && !in_standby, "R7 ready low before ack", {ready, in_standby}, 0);
    cycles(20);
    chk(in_standby, "R7 standby after ack", in_standby, 1);
    mon_half = 1.5;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (vdd_code != 4'd0 || bias_code != 3'd4 || !in_standby) steady = 0;
    end
    chk(steady, "R7 park held under clock change", steady, 1);
    sleep_req = 1'b0;
    @(negedge clk);
    chk(vdd_code == 4'd10 && bias_code == 3'd0, "R8 restored point", vdd_code, 10);
    chk(!ready && !in_standby, "R8 ready waits for ack", {ready, in_standby}, 0);
    cycles(10);
    chk(ready, "R8 ready after ack", ready, 1);
    cycles(200);
    chk(vdd_code == 4'd3 && bias_code == 3'd2, "R2 vdd at 333MHz", vdd_code, 3);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    reg_live = 1;
    t_down_to_min();
    t_up_held_ack();
    t_hysteresis();
    t_top();
    t_standby();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule